// File: doc/BRIEF.md
# Issue Queue with Tag Wakeup

This block holds renamed instructions until their operands are available and reports, every cycle, which of its slots could be issued. Each slot records a sequence number, a class code, two physical source tags with per-source ready bits, and a hold flag. The hold flag is used for instructions that must wait until commit, such as stores and non-speculative operations. A scoreboard with one bit per physical register decides at dispatch whether a source already has its value or must wait for a completion broadcast carrying its tag.

An external selector reads the request vector together with the per-slot sequence numbers and classes. It returns a grant vector, and each granted slot is released at once. A hold is lifted by a release that names the slot's exact sequence number. A squash names a sequence number and cancels every younger slot still waiting. A tag at or above the physical register count names an unrenamed special register: it never waits and never marks anything busy.

Top module: `issue_queue`

## Requirements
- R1: While reset is high, and on the first cycle after it, the free count is DEPTH, full is low and no request bit is set. Every scoreboard bit starts ready.
- R2: An accepted dispatch fills the lowest-indexed free slot. After the edge, that slot's sequence number appears on its field of `ent_seq_o` (slot i at bits i*SEQ_W upward) and the free count drops by one. Full is high exactly when the free count is zero, and a dispatch offered while full is dropped without changing any slot.
- R3: At dispatch a source is marked ready when any of these holds: its scoreboard bit is ready, a completion broadcast of the same tag arrives in the same cycle, or its tag is at least NPHYS. A slot with both sources ready and no hold raises its request bit in the cycle after dispatch.
- R4: An accepted dispatch whose destination tag is below NPHYS marks that register not-ready. A later consumer of that tag dispatched without a matching broadcast waits. A destination tag at or above NPHYS changes no scoreboard bit.
- R5: A completion broadcast marks every waiting source with the same tag as ready and sets that tag's scoreboard bit. A slot woken this way raises its request bit in the cycle after the broadcast.
- R6: A slot dispatched with hold set never requests until a release carries its exact sequence number. A release with any other sequence number has no effect. After a matching release, the slot requests from the next cycle once its sources are ready.
- R7: On a squash, every slot whose sequence number is strictly greater than the squash sequence number (unsigned compare) loses its request bit after that edge and is freed one edge later. Older slots and a dispatch accepted in the same cycle are unaffected.
- R8: A grant bit on a requesting slot frees that slot at the same edge. A grant bit on a slot that is not requesting is ignored.
- R9: The free count always equals DEPTH minus the number of occupied slots, where squashed slots stay occupied for one cycle, so set request bits never outnumber occupied slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_valid_i | input | 1 | Dispatch offer |
| disp_seq_i | input | SEQ_W | Sequence number of the offered instruction |
| disp_cls_i | input | CLS_W | Class code, carried to the selector |
| disp_src0_i | input | TAG_W | First source tag |
| disp_src1_i | input | TAG_W | Second source tag |
| disp_dst_i | input | TAG_W | Destination tag |
| disp_hold_i | input | 1 | Hold until released by sequence number |
| wb_valid_i | input | 1 | Completion broadcast valid |
| wb_tag_i | input | TAG_W | Completed destination tag |
| rel_valid_i | input | 1 | Hold release valid |
| rel_seq_i | input | SEQ_W | Sequence number to release |
| sq_valid_i | input | 1 | Squash valid |
| sq_seq_i | input | SEQ_W | Squash boundary; younger slots are cancelled |
| grant_i | input | DEPTH | Issue grant per slot |
| req_o | output | DEPTH | Per-slot issue request |
| full_o | output | 1 | No free slot |
| free_cnt_o | output | $clog2(DEPTH+1) | Number of free slots |
| ent_seq_o | output | DEPTH*SEQ_W | Sequence number of every slot |
| ent_cls_o | output | DEPTH*CLS_W | Class code of every slot |

## Verification
The bench builds the queue with DEPTH=4, SEQ_W=10, TAG_W=4 and NPHYS=12. With only four slots, the full condition and dropped dispatches occur often. With a sixteen-tag space, random sources collide with busy destinations and with broadcasts in the same cycle. A quarter of all tags fall in the bypass range, so special-register operands and destinations arise naturally. The ten-bit sequence width, with periodic resets, keeps the numbers monotonic so that squash boundaries split the live slots in varied ways.

// File: rtl/iq_pkg.sv
package iq_pkg;

  typedef struct packed {
    logic valid;
    logic squashed;
    logic held;
    logic rdy0;
    logic rdy1;
  } iq_flags_t;

  function automatic logic wants_issue(iq_flags_t f);
    return f.valid & ~f.squashed & ~f.held & f.rdy0 & f.rdy1;
  endfunction

endpackage

// File: rtl/iq_scoreboard.sv
module iq_scoreboard #(
  parameter int TAG_W = 6,
  parameter int NPHYS = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wb_valid_i,
  input  logic [TAG_W-1:0] wb_tag_i,
  input  logic             busy_i,
  input  logic [TAG_W-1:0] busy_tag_i,
  input  logic [TAG_W-1:0] q0_tag_i,
  input  logic [TAG_W-1:0] q1_tag_i,
  output logic             q0_rdy_o,
  output logic             q1_rdy_o
);
  localparam int TAGS = 1 << TAG_W;

  logic [TAGS-1:0] ready_q;

  function automatic logic special(logic [TAG_W-1:0] t);
    return 32'(t) >= NPHYS;
  endfunction

  // Forward a same-cycle broadcast so a source is never stranded.
  assign q0_rdy_o = special(q0_tag_i) | ready_q[q0_tag_i] |
                    (wb_valid_i && wb_tag_i == q0_tag_i);
  assign q1_rdy_o = special(q1_tag_i) | ready_q[q1_tag_i] |
                    (wb_valid_i && wb_tag_i == q1_tag_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= '1;
    end else begin
      if (wb_valid_i) ready_q[wb_tag_i] <= 1'b1;
      if (busy_i && !special(busy_tag_i)) ready_q[busy_tag_i] <= 1'b0;
    end
  end
endmodule

// File: rtl/iq_alloc.sv
module iq_alloc #(
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH-1:0] valid_i,
  output logic [DEPTH-1:0] pick_o,
  output logic             any_free_o,
  output logic [CNT_W-1:0] free_cnt_o
);
  always_comb begin
    pick_o     = '0;
    any_free_o = 1'b0;
    free_cnt_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!valid_i[i]) begin
        if (!any_free_o) pick_o[i] = 1'b1;
        any_free_o = 1'b1;
        free_cnt_o = free_cnt_o + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/iq_entry.sv
module iq_entry
  import iq_pkg::*;
#(
  parameter int SEQ_W = 8,
  parameter int TAG_W = 6,
  parameter int CLS_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [SEQ_W-1:0] ld_seq_i,
  input  logic [CLS_W-1:0] ld_cls_i,
  input  logic [TAG_W-1:0] ld_src0_i,
  input  logic [TAG_W-1:0] ld_src1_i,
  input  logic             ld_hold_i,
  input  logic             ld_rdy0_i,
  input  logic             ld_rdy1_i,
  input  logic             wb_valid_i,
  input  logic [TAG_W-1:0] wb_tag_i,
  input  logic             rel_valid_i,
  input  logic [SEQ_W-1:0] rel_seq_i,
  input  logic             sq_valid_i,
  input  logic [SEQ_W-1:0] sq_seq_i,
  input  logic             grant_i,
  output logic             valid_o,
  output logic             req_o,
  output logic [SEQ_W-1:0] seq_o,
  output logic [CLS_W-1:0] cls_o
);
  iq_flags_t        f_q;
  logic [TAG_W-1:0] src0_q, src1_q;

  assign valid_o = f_q.valid;
  assign req_o   = wants_issue(f_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      f_q    <= '0;
      seq_o  <= '0;
      cls_o  <= '0;
      src0_q <= '0;
      src1_q <= '0;
    end else if (load_i) begin
      f_q    <= '{valid: 1'b1, squashed: 1'b0, held: ld_hold_i,
                  rdy0: ld_rdy0_i, rdy1: ld_rdy1_i};
      seq_o  <= ld_seq_i;
      cls_o  <= ld_cls_i;
      src0_q <= ld_src0_i;
      src1_q <= ld_src1_i;
    end else if (f_q.valid) begin
      if (f_q.squashed || (grant_i && req_o)) begin
        f_q <= '0;
      end else begin
        if (wb_valid_i && wb_tag_i == src0_q) f_q.rdy0 <= 1'b1;
        if (wb_valid_i && wb_tag_i == src1_q) f_q.rdy1 <= 1'b1;
        if (rel_valid_i && rel_seq_i == seq_o) f_q.held <= 1'b0;
        if (sq_valid_i && seq_o > sq_seq_i) begin
          f_q.squashed <= 1'b1;
          f_q.held     <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/issue_queue.sv
module issue_queue #(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 8,
  parameter int TAG_W = 6,
  parameter int NPHYS = 48,
  parameter int CLS_W = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       disp_valid_i,
  input  logic [SEQ_W-1:0]           disp_seq_i,
  input  logic [CLS_W-1:0]           disp_cls_i,
  input  logic [TAG_W-1:0]           disp_src0_i,
  input  logic [TAG_W-1:0]           disp_src1_i,
  input  logic [TAG_W-1:0]           disp_dst_i,
  input  logic                       disp_hold_i,
  input  logic                       wb_valid_i,
  input  logic [TAG_W-1:0]           wb_tag_i,
  input  logic                       rel_valid_i,
  input  logic [SEQ_W-1:0]           rel_seq_i,
  input  logic                       sq_valid_i,
  input  logic [SEQ_W-1:0]           sq_seq_i,
  input  logic [DEPTH-1:0]           grant_i,
  output logic [DEPTH-1:0]           req_o,
  output logic                       full_o,
  output logic [$clog2(DEPTH+1)-1:0] free_cnt_o,
  output logic [DEPTH*SEQ_W-1:0]     ent_seq_o,
  output logic [DEPTH*CLS_W-1:0]     ent_cls_o
);
  logic [DEPTH-1:0] valid, pick;
  logic             any_free, accept, s0_rdy, s1_rdy;

  assign full_o = ~any_free;
  assign accept = disp_valid_i & any_free;

  iq_scoreboard #(.TAG_W(TAG_W), .NPHYS(NPHYS)) u_sb (
    .clk        (clk),
    .rst        (rst),
    .wb_valid_i (wb_valid_i),
    .wb_tag_i   (wb_tag_i),
    .busy_i     (accept),
    .busy_tag_i (disp_dst_i),
    .q0_tag_i   (disp_src0_i),
    .q1_tag_i   (disp_src1_i),
    .q0_rdy_o   (s0_rdy),
    .q1_rdy_o   (s1_rdy)
  );

  iq_alloc #(.DEPTH(DEPTH)) u_alloc (
    .valid_i    (valid),
    .pick_o     (pick),
    .any_free_o (any_free),
    .free_cnt_o (free_cnt_o)
  );

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    iq_entry #(.SEQ_W(SEQ_W), .TAG_W(TAG_W), .CLS_W(CLS_W)) u_ent (
      .clk         (clk),
      .rst         (rst),
      .load_i      (accept & pick[g]),
      .ld_seq_i    (disp_seq_i),
      .ld_cls_i    (disp_cls_i),
      .ld_src0_i   (disp_src0_i),
      .ld_src1_i   (disp_src1_i),
      .ld_hold_i   (disp_hold_i),
      .ld_rdy0_i   (s0_rdy),
      .ld_rdy1_i   (s1_rdy),
      .wb_valid_i  (wb_valid_i),
      .wb_tag_i    (wb_tag_i),
      .rel_valid_i (rel_valid_i),
      .rel_seq_i   (rel_seq_i),
      .sq_valid_i  (sq_valid_i),
      .sq_seq_i    (sq_seq_i),
      .grant_i     (grant_i[g]),
      .valid_o     (valid[g]),
      .req_o       (req_o[g]),
      .seq_o       (ent_seq_o[g*SEQ_W +: SEQ_W]),
      .cls_o       (ent_cls_o[g*CLS_W +: CLS_W])
    );
  end
endmodule

// File: rtl/iq_checker.sv
module iq_checker #(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 8
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       disp_valid_i,
  input logic                       full_o,
  input logic [$clog2(DEPTH+1)-1:0] free_cnt_o,
  input logic [DEPTH-1:0]           req_o,
  input logic [DEPTH-1:0]           grant_i,
  input logic                       sq_valid_i,
  input logic [SEQ_W-1:0]           sq_seq_i,
  input logic [DEPTH*SEQ_W-1:0]     ent_seq_o
);
  AST_RESET_EMPTY: assert property (@(posedge clk)
    rst |=> (32'(free_cnt_o) == DEPTH && req_o == '0)); // R1

  AST_REQ_WITHIN_OCC: assert property (@(posedge clk) disable iff (rst)
    32'($countones(req_o)) + 32'(free_cnt_o) <= DEPTH); // R9

  AST_FREE_ONLY_DISP: assert property (@(posedge clk) disable iff (rst)
    !(disp_valid_i && !full_o) |=> free_cnt_o >= $past(free_cnt_o)); // R9

  AST_GRANT_FREES: assert property (@(posedge clk) disable iff (rst)
    (|(grant_i & req_o) && !disp_valid_i) |=> free_cnt_o > $past(free_cnt_o)); // R8

  for (genvar i = 0; i < DEPTH; i++) begin : g_sq
    AST_SQUASH_DROPS: assert property (@(posedge clk) disable iff (rst)
      (sq_valid_i && req_o[i] && !grant_i[i] &&
       ent_seq_o[i*SEQ_W +: SEQ_W] > sq_seq_i) |=> !req_o[i]); // R7
  end
endmodule

bind issue_queue iq_checker #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) i_iq_checker (
  .clk          (clk),
  .rst          (rst),
  .disp_valid_i (disp_valid_i),
  .full_o       (full_o),
  .free_cnt_o   (free_cnt_o),
  .req_o        (req_o),
  .grant_i      (grant_i),
  .sq_valid_i   (sq_valid_i),
  .sq_seq_i     (sq_seq_i),
  .ent_seq_o    (ent_seq_o)
);

// File: tb/test_issue_queue.sv
module test_issue_queue;
  localparam int D    = 4;
  localparam int SW   = 10;
  localparam int TW   = 4;
  localparam int NP   = 12;
  localparam int CW   = 3;
  localparam int TAGS = 1 << TW;
  localparam int FW   = $clog2(D + 1);

  logic clk = 1'b0, rst = 1'b1;
  logic disp_valid = 0, disp_hold = 0, wb_valid = 0, rel_valid = 0, sq_valid = 0;
  logic [SW-1:0] disp_seq = '0, rel_seq = '0, sq_seq = '0;
  logic [CW-1:0] disp_cls = '0;
  logic [TW-1:0] src0 = '0, src1 = '0, dst = '0, wb_tag = '0;
  logic [D-1:0]  grant = '0, req;
  logic          full;
  logic [FW-1:0] free_cnt;
  logic [D*SW-1:0] ent_seq;
  logic [D*CW-1:0] ent_cls;

  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  issue_queue #(.DEPTH(D), .SEQ_W(SW), .TAG_W(TW), .NPHYS(NP), .CLS_W(CW)) i_issue_queue (
    .clk(clk), .rst(rst), .disp_valid_i(disp_valid), .disp_seq_i(disp_seq),
    .disp_cls_i(disp_cls), .disp_src0_i(src0), .disp_src1_i(src1),
    .disp_dst_i(dst), .disp_hold_i(disp_hold), .wb_valid_i(wb_valid),
    .wb_tag_i(wb_tag), .rel_valid_i(rel_valid), .rel_seq_i(rel_seq),
    .sq_valid_i(sq_valid), .sq_seq_i(sq_seq), .grant_i(grant),
    .req_o(req), .full_o(full), .free_cnt_o(free_cnt),
    .ent_seq_o(ent_seq), .ent_cls_o(ent_cls));

  // Reference state, built from the requirements
  bit m_v[D], m_sq[D], m_h[D], m_r0[D], m_r1[D];
  logic [SW-1:0] m_seq[D];
  logic [TW-1:0] m_s0[D], m_s1[D];
  bit m_sb[TAGS];

  function automatic logic [D-1:0] m_req();
    logic [D-1:0] r;
    for (int i = 0; i < D; i++) r[i] = m_v[i] & !m_sq[i] & !m_h[i] & m_r0[i] & m_r1[i];
    return r;
  endfunction

  function automatic int m_free();
    int n = 0;
    for (int i = 0; i < D; i++) if (!m_v[i]) n++;
    return n;
  endfunction

  function automatic bit src_ok(logic [TW-1:0] t);
    return (int'(t) >= NP) || m_sb[t] || (wb_valid && wb_tag == t);
  endfunction

  task automatic model_step();
    logic [D-1:0] er;
    bit acc, r0n, r1n;
    int slot;
    if (rst) begin
      for (int i = 0; i < D; i++) begin
        m_v[i] = 0; m_sq[i] = 0; m_h[i] = 0; m_r0[i] = 0; m_r1[i] = 0; m_seq[i] = '0;
      end
      for (int t = 0; t < TAGS; t++) m_sb[t] = 1;
      return;
    end
    acc = disp_valid && (m_free() != 0);
    slot = -1;
    for (int i = D - 1; i >= 0; i--) if (!m_v[i]) slot = i;
    r0n = src_ok(src0);
    r1n = src_ok(src1);
    er = m_req();
    for (int i = 0; i < D; i++) begin
      if (m_v[i]) begin
        if (m_sq[i] || (grant[i] && er[i])) m_v[i] = 0;
        else begin
          if (wb_valid && wb_tag == m_s0[i]) m_r0[i] = 1;
          if (wb_valid && wb_tag == m_s1[i]) m_r1[i] = 1;
          if (rel_valid && rel_seq == m_seq[i]) m_h[i] = 0;
          if (sq_valid && m_seq[i] > sq_seq) begin m_sq[i] = 1; m_h[i] = 0; end
        end
      end
    end
    if (wb_valid) m_sb[wb_tag] = 1;
    if (acc && int'(dst) < NP) m_sb[dst] = 0;
    if (acc) begin
      m_v[slot] = 1; m_sq[slot] = 0; m_h[slot] = disp_hold;
      m_r0[slot] = r0n; m_r1[slot] = r1n; m_seq[slot] = disp_seq;
      m_s0[slot] = src0; m_s1[slot] = src1;
    end
  endtask

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R5 req vs reference", 32'(req), 32'(m_req()));
    chk("R9 free count vs reference", 32'(free_cnt), 32'(m_free()));
    chk("R2 full vs reference", 32'(full), 32'(m_free() == 0));
    for (int i = 0; i < D; i++)
      if (m_v[i]) chk("R2 slot seq vs reference", 32'(ent_seq[i*SW +: SW]), 32'(m_seq[i]));
  endtask

  task automatic idle();
    disp_valid = 0; disp_hold = 0; wb_valid = 0; rel_valid = 0; sq_valid = 0; grant = '0;
  endtask

  task automatic cyc();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    idle();
  endtask

  task automatic disp(int s, int a, int b, int d, bit h);
    disp_valid = 1; disp_seq = SW'(s); src0 = TW'(a); src1 = TW'(b); dst = TW'(d);
    disp_hold = h; disp_cls = CW'(s);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int nseq;
    @(negedge clk);
    rst = 1; idle(); cyc(); cyc();
    rst = 0;
    chk("R1 reset req", 32'(req), 0);
    chk("R1 reset free", 32'(free_cnt), D);
    chk("R1 reset full", 32'(full), 0);

    disp(1, 3, 12, 5, 0); cyc();                 // ready source plus special source
    chk("R3 ready at dispatch", 32'(req), 32'h1);
    chk("R2 free after dispatch", 32'(free_cnt), 3);
    chk("R2 slot0 seq", 32'(ent_seq[0 +: SW]), 1);
    disp(2, 5, 13, 6, 0); cyc();                 // waits on tag 5
    chk("R4 consumer waits", 32'(req), 32'h1);
    wb_valid = 1; wb_tag = 5; cyc();
    chk("R5 broadcast wakes", 32'(req), 32'h3);
    grant = 4'b0101; cyc();                      // bit 2 names an empty slot
    chk("R8 grant frees", 32'(free_cnt), 3);
    chk("R8 stray grant ignored", 32'(req), 32'h2);
    disp(3, 1, 2, 14, 1); cyc();                 // held, special destination
    chk("R6 held no request", 32'(req), 32'h2);
    chk("R2 lowest free slot", 32'(ent_seq[0 +: SW]), 3);
    rel_valid = 1; rel_seq = 4; cyc();
    chk("R6 wrong release ignored", 32'(req), 32'h2);
    rel_valid = 1; rel_seq = 3; cyc();
    chk("R6 release frees hold", 32'(req), 32'h3);
    disp(4, 6, 12, 7, 0); wb_valid = 1; wb_tag = 6; cyc();
    chk("R3 same-cycle broadcast forwarded", 32'(req), 32'h7);
    disp(5, 7, 13, 8, 0); cyc();
    chk("R4 pending producer blocks", 32'(req), 32'h7);
    chk("R2 full asserted", 32'(full), 1);
    disp(6, 0, 0, 9, 0); cyc();
    chk("R2 full drops dispatch", 32'(free_cnt), 0);
    chk("R2 slot3 unchanged", 32'(ent_seq[3*SW +: SW]), 5);
    sq_valid = 1; sq_seq = 3; cyc();
    chk("R7 squash drops younger", 32'(req), 32'h3);
    chk("R7 squashed still occupied", 32'(free_cnt), 0);
    cyc();
    chk("R7 squashed freed", 32'(free_cnt), 2);
    grant = 4'b0011; cyc();
    chk("R8 all granted", 32'(free_cnt), D);
    disp(7, 14, 15, 15, 0); cyc();
    chk("R4 special dst leaves tag usable", 32'(req), 32'h1);

    void'($urandom(32'd12345));
    nseq = 10;
    for (int k = 0; k < 3000; k++) begin
      if (k % 250 == 0) begin
        rst = 1; cyc(); rst = 0; nseq = 1;
      end
      if ($urandom % 10 < 6) begin
        disp(nseq, $urandom % TAGS, $urandom % TAGS, $urandom % TAGS, ($urandom % 5) == 0);
        if (m_free() != 0) nseq++;
      end
      if ($urandom % 10 < 4) begin wb_valid = 1; wb_tag = TW'($urandom); end
      if ($urandom % 5 == 0) begin
        rel_valid = 1;
        rel_seq = SW'($urandom % (nseq + 1));
        for (int i = 0; i < D; i++) if (m_v[i] && m_h[i] && ($urandom % 2 == 0)) rel_seq = m_seq[i];
      end
      if ($urandom % 30 == 0 && nseq > 4) begin
        sq_valid = 1; sq_seq = SW'(nseq - 1 - int'($urandom % 4));
      end
      grant = D'($urandom);
      cyc();
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule